// File: doc/BRIEF.md
# Shared RAM Page Port Arbiter

This block owns one single-port page of a large on-chip RAM and shares its only read/write port among six bus masters: four graphics buses, a DMA bus and a CPU bus. In every cycle it looks at the requests, grants the port to exactly one master, and performs that master's access. A write lands in the page at the clock edge that ends the grant cycle. A read returns registered data on the winner's own read-data lane one cycle later.

The four graphics buses rank above everything else, in fixed order. Below them, the CPU bus and the DMA bus swap places depending on history. A one-bit register remembers whether the CPU bus held the port in the previous cycle. If it did not, the CPU bus outranks the DMA bus. If it did, the DMA bus wins. The result is that a CPU bus requesting every cycle cannot lock out a waiting DMA transfer.

Masters that lose keep their request raised and are served in a later cycle. Page decoding is done upstream, so the block only sees requests that target its page.

Top module: `rampg_page_port`

## Requirements
- R1: Per cycle, at most one grant bit is high. A grant is given whenever at least one request is high, and no grant is given when no request is high. The grant is combinational from the current requests. Master indices are: 0 to 3 for graphics buses 0 to 3, 4 for the DMA bus, and 5 for the CPU bus.
- R2: A grant goes only to a master whose request is high.
- R3: Among the graphics buses, a lower index wins over a higher one. Any graphics request wins over both the DMA bus and the CPU bus.
- R4: If the CPU bus (index 5) was not granted in the previous cycle and no graphics bus requests, the CPU bus wins over the DMA bus (index 4).
- R5: If the CPU bus was granted in the previous cycle and no graphics bus requests, the DMA bus wins over the CPU bus. With both requesting continuously, the grant therefore alternates between them, starting with the CPU bus.
- R6: Any cycle in which the CPU bus is not granted clears the history. This includes an idle cycle and a cycle won by a graphics bus. In the cycle after such a cycle, the CPU bus again wins over the DMA bus.
- R7: The granted master's write, with its address and data, is committed at the clock edge that ends its grant cycle. A losing master's held write is committed when it is later granted.
- R8: A read granted in cycle k presents the page word at that address on the winner's read-data lane during cycle k+1. In that cycle every other lane reads zero, and after a write grant or an idle cycle all lanes read zero.
- R9: After reset, all read-data lanes are zero and the history is clear, so the CPU bus wins over the DMA bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Per-master access request |
| we | input | 6 | Per-master write enable (1 = write, 0 = read) |
| addr | input | 6*ADDR_W | Per-master word address; master m uses slice [m*ADDR_W +: ADDR_W] |
| wdata | input | 6*DATA_W | Per-master write data; master m uses slice [m*DATA_W +: DATA_W] |
| gnt | output | 6 | One-hot grant, combinational in the request cycle |
| rdata | output | 6*DATA_W | Per-master read data, valid the cycle after a read grant, zero otherwise |

## Verification
A history bit stuck or inverted shows up within one cycle of a CPU-bus grant. The next cycle with both the CPU and DMA buses requesting gives the wrong winner, and the alternation pattern breaks at once. A wrong read-owner register or memory select shows on the read-data lanes one cycle after the grant: data appears on the wrong lane, non-zero data appears after a write, or the wrong word is returned. A broken priority picker shows in the same cycle as the request, as a wrong or multiple grant.

// File: rtl/rampg_pkg.sv
package rampg_pkg;
  localparam int N_MST   = 6;
  localparam int N_GFX   = 4;
  localparam int IDX_DMA = 4;
  localparam int IDX_CPU = 5;
endpackage

// File: rtl/rampg_prio_pick.sv
// Fixed-priority one-hot picker: bit 0 is the highest rank.
module rampg_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !taken) begin
        pick[i] = 1'b1;
        taken   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rampg_arbiter.sv
// Arbiter with history-dependent rank between the CPU and DMA buses.
module rampg_arbiter
  import rampg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] gnt
);
  logic             cpu_last;
  int unsigned      lo_first, lo_second;
  logic [N_MST-1:0] ranked, picked;

  always_comb begin
    lo_first  = cpu_last ? IDX_DMA : IDX_CPU;
    lo_second = cpu_last ? IDX_CPU : IDX_DMA;
  end

  // Ranked candidate vector: graphics buses first, then the two low masters.
  always_comb begin
    ranked = '0;
    for (int g = 0; g < N_GFX; g++) ranked[g] = req[g];
    ranked[N_GFX]     = req[lo_first];
    ranked[N_GFX + 1] = req[lo_second];
  end

  rampg_prio_pick #(.N(N_MST)) u_pick (
    .cand (ranked),
    .pick (picked)
  );

  always_comb begin
    gnt = '0;
    for (int g = 0; g < N_GFX; g++) gnt[g] = picked[g];
    gnt[lo_first]  = picked[N_GFX];
    gnt[lo_second] = picked[N_GFX + 1];
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_last <= 1'b0;
    else     cpu_last <= gnt[IDX_CPU];
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (gnt != '0));
  p_only_req_r2: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  p_gfx_first_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt[IDX_DMA] || gnt[IDX_CPU]) |-> (req[N_GFX-1:0] == '0));
  p_cpu_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_last && req[IDX_CPU] && req[N_GFX-1:0] == '0) |-> gnt[IDX_CPU]);
  p_dma_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt[IDX_CPU] && req[IDX_DMA]) |=> (req[N_GFX-1:0] != '0) || gnt[IDX_DMA] || !req[IDX_DMA]);
  p_hist_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (!gnt[IDX_CPU]) |=> (req[IDX_CPU] && req[N_GFX-1:0] == '0) |-> gnt[IDX_CPU]);
endmodule

// File: rtl/rampg_sp_mem.sv
// Single-port read-first RAM, written for block RAM inference.
module rampg_sp_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] a,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) mem[a] <= d;
      q <= mem[a];
    end
  end
endmodule

// File: rtl/rampg_page_port.sv
module rampg_page_port
  import rampg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MST-1:0]        req,
  input  logic [N_MST-1:0]        we,
  input  logic [N_MST*ADDR_W-1:0] addr,
  input  logic [N_MST*DATA_W-1:0] wdata,
  output logic [N_MST-1:0]        gnt,
  output logic [N_MST*DATA_W-1:0] rdata
);
  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic [DATA_W-1:0] mem_q;
  logic [N_MST-1:0]  rd_owner;

  rampg_arbiter u_arb (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
  );

  // AND-OR select of the winner's access (grant is one-hot).
  always_comb begin
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int m = 0; m < N_MST; m++) begin
      sel_we    = sel_we    | (gnt[m] & we[m]);
      sel_addr  = sel_addr  | ({ADDR_W{gnt[m]}} & addr[m*ADDR_W +: ADDR_W]);
      sel_wdata = sel_wdata | ({DATA_W{gnt[m]}} & wdata[m*DATA_W +: DATA_W]);
    end
  end

  rampg_sp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk (clk),
    .en  (|gnt),
    .wr  (sel_we),
    .a   (sel_addr),
    .d   (sel_wdata),
    .q   (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_owner <= '0;
    else     rd_owner <= gnt & ~we;
  end

  generate
    for (genvar m = 0; m < N_MST; m++) begin : g_lane
      assign rdata[m*DATA_W +: DATA_W] = rd_owner[m] ? mem_q : '0;

      p_lane_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !(gnt[m] && !we[m]) |=> (rdata[m*DATA_W +: DATA_W] == '0));
    end
  endgenerate
endmodule

// File: tb/rampg_page_port_tb.sv
`timescale 1ns/1ps
module rampg_page_port_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rst;
  logic [NM-1:0]    req, we;
  logic [NM*AW-1:0] addr;
  logic [NM*DW-1:0] wdata;
  logic [NM-1:0]    gnt;
  logic [NM*DW-1:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rampg_page_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .gnt(gnt), .rdata(rdata)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic idle();
    req = '0; we = '0; addr = '0; wdata = '0;
  endtask

  task automatic drive(input int m, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    req[m] = 1'b1; we[m] = w;
    addr[m*AW +: AW] = a; wdata[m*DW +: DW] = d;
  endtask

  task automatic drop(input int m);
    req[m] = 1'b0; we[m] = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_gnt(input string tag, input logic [NM-1:0] exp);
    #1;
    n_chk++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt actual %b expected %b", tag, gnt, exp);
    end
  endtask

  task automatic chk_lanes(input string tag, input int m, input logic [DW-1:0] exp);
    n_chk++;
    for (int k = 0; k < NM; k++) begin
      logic [DW-1:0] e;
      e = (k == m) ? exp : '0;
      if (rdata[k*DW +: DW] !== e) begin
        n_fail++;
        $display("FAIL %s: lane %0d actual %h expected %h", tag, k, rdata[k*DW +: DW], e);
      end
    end
  endtask

  task automatic t_reset();
    chk_lanes("R9 lanes zero after reset", -1, '0);
    drive(4, 1'b0, 8'h00, '0);
    drive(5, 1'b0, 8'h00, '0);
    chk_gnt("R9 cpu first after reset", 6'b100000);
    idle(); tick();
  endtask

  task automatic t_priority();
    for (int m = 0; m < NM; m++) drive(m, 1'b0, 8'h01, '0);
    chk_gnt("R3 gfx0 wins all", 6'b000001);
    drop(0);
    chk_gnt("R3 gfx1 next", 6'b000010);
    drop(1); drop(2);
    chk_gnt("R3 gfx3 over dma/cpu", 6'b001000);
    idle();
    chk_gnt("R1 no request no grant", 6'b000000);
    drive(3, 1'b0, 8'h02, '0);
    chk_gnt("R2 lone request granted", 6'b001000);
    idle(); tick();
  endtask

  task automatic t_alternate();
    drive(4, 1'b0, 8'h03, '0);
    drive(5, 1'b0, 8'h04, '0);
    for (int i = 0; i < 6; i++) begin
      chk_gnt("R5 cpu/dma alternate", (i % 2 == 0) ? 6'b100000 : 6'b010000);
      tick();
    end
    idle(); tick();
  endtask

  task automatic t_history_clear();
    drive(5, 1'b0, 8'h05, '0);
    chk_gnt("R4 cpu alone", 6'b100000);
    tick();
    idle(); tick();
    drive(4, 1'b0, 8'h06, '0);
    drive(5, 1'b0, 8'h05, '0);
    chk_gnt("R6 idle clears history", 6'b100000);
    tick();
    drive(0, 1'b0, 8'h07, '0);
    chk_gnt("R3 gfx0 interrupts", 6'b000001);
    tick();
    drop(0);
    chk_gnt("R6 gfx grant clears history", 6'b100000);
    tick();
    chk_gnt("R5 dma after cpu grant", 6'b010000);
    idle(); tick();
  endtask

  task automatic t_memory();
    drive(2, 1'b1, 8'h05, 32'hA5A5_0001);
    chk_gnt("R7 gfx2 write granted", 6'b000100);
    tick();
    idle();
    chk_lanes("R8 lanes zero after write", -1, '0);
    drive(4, 1'b0, 8'h05, '0);
    chk_gnt("R8 dma read granted", 6'b010000);
    tick();
    idle();
    chk_lanes("R7 R8 dma reads written word", 4, 32'hA5A5_0001);
    tick();
    chk_lanes("R8 lanes zero after idle", -1, '0);
    drive(0, 1'b1, 8'h09, 32'h0000_B0B0);
    drive(1, 1'b1, 8'h09, 32'h0000_C1C1);
    chk_gnt("R7 gfx0 write first", 6'b000001);
    tick();
    drop(0);
    chk_gnt("R7 held gfx1 write served", 6'b000010);
    tick();
    idle();
    drive(5, 1'b0, 8'h09, '0);
    tick();
    idle();
    chk_lanes("R7 later write wins", 5, 32'h0000_C1C1);
    drive(3, 1'b0, 8'h05, '0);
    tick();
    idle();
    chk_lanes("R8 gfx3 lane only", 3, 32'hA5A5_0001);
    tick();
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_priority();
    t_alternate();
    t_history_clear();
    t_memory();
    finish_run();
  end
endmodule